// File: doc/BRIEF.md
# Memory Self-Test Write Sequencer

This block fills a region of word-addressed memory with a known test sequence so that a later read pass can compare against it. Software sets a byte base, a byte end and a byte length, and two mode bits that choose random-address and random-data scrambling. A one-cycle start pulse begins a run, and a done level reports when every write has been accepted. The block drives a native memory write port. That port has a command channel (valid, ready, write-enable, word address) and a separate write-data channel (valid, ready, data). Both channels carry full backpressure.

The byte settings become word quantities by dividing by the data width in bytes. The word offset of each transfer is masked to the window `(end - base)`, so addresses wrap inside that window. Address and data can each be taken from a sequential count or from a 23-bit linear feedback shift register. Control is a three-state machine. `ST_IDLE` is the state after reset. `ST_XFER` issues transfers. `ST_DONE` holds after a run. The transitions are:
- `ST_IDLE`/`ST_DONE` → `ST_XFER` on start with a non-zero word count.
- `ST_IDLE`/`ST_DONE` → `ST_DONE` on start with a zero word count.
- `ST_XFER` → `ST_DONE` when the last transfer completes.
- Any state → `ST_IDLE` on reset.

Top module: `mbw_gen`

## Requirements
- R1: `done` is 1 in `ST_IDLE` and `ST_DONE` and 0 in `ST_XFER`. It is 0 from the clock edge that samples `start` until the last transfer completes, and 1 from the edge after that completion. No channel valid is raised while `done` is 1.
- R2: The reset is asynchronous and active-low (`rst_n = 0`). It ends any run at once: `done` goes to 1 and both valids go to 0. It also reloads the scrambler with its seed value 1.
- R3: The first word address of a sequential run is `base / (DATA_W/8)`. For example, byte base 16 at 32 bits gives word 4.
- R4: A run makes exactly `length / (DATA_W/8)` transfers. A zero word count goes directly to `ST_DONE` and issues nothing.
- R5: The word address of transfer k is `base_w + (offset_k & (span_w - 1))`, where `span_w = (end - base) / (DATA_W/8)` is a power of two. Addresses therefore wrap inside the window.
- R6: With random data off, transfer k (counting from 0 within the run) writes the value k, zero-extended to DATA_W.
- R7: With random data on, transfer k writes the scrambler state before its step, zero-extended or truncated to DATA_W. The state starts at 1 and steps to `{s[21:0], s[22]^s[17]}`. It steps once per completed transfer and never otherwise, and it persists across runs.
- R8: With random address on, `offset_k` is the scrambler state (zero-extended). Data follows R6 or R7 independently of this setting.
- R9: The command and data of one transfer may be accepted in the same cycle or in different cycles. Each valid holds, with its payload stable, until that channel is accepted. The next transfer starts only after both channels of the current one are accepted. Every command has write-enable 1.
- R10: A start pulse during `ST_XFER` is ignored. Configuration inputs are sampled only on the start that begins a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle run request |
| base_bytes | input | CFG_W | Window start in bytes |
| end_bytes | input | CFG_W | Window end in bytes |
| len_bytes | input | CFG_W | Run length in bytes |
| rnd_addr | input | 1 | Scramble word offset |
| rnd_data | input | 1 | Scramble written data |
| done | output | 1 | Run finished / idle |
| cmd_valid | output | 1 | Command valid |
| cmd_ready | input | 1 | Command accepted |
| cmd_we | output | 1 | Write enable of command |
| cmd_addr | output | ADDR_W | Word address |
| wd_valid | output | 1 | Write data valid |
| wd_ready | input | 1 | Write data accepted |
| wd_data | output | DATA_W | Write data word |

## Verification
The two acceptances of one transfer, command and write data, can happen in the same cycle or in different cycles. Completion of the transfer has to come from either order. The bench drives the two readies with different stall rhythms, so some transfers have both accepted together and others have one channel waiting on the other. The paired address and data logs are then compared entry by entry against the modelled sequence. A slip in either order would duplicate, drop or shift an entry, and would advance the scrambler at the wrong moment.

// File: rtl/mbw_pkg.sv
package mbw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_DONE = 2'd2
    } mbw_state_e;

    localparam int unsigned SCR_W    = 23;
    localparam int unsigned SCR_TAP_A = 22;
    localparam int unsigned SCR_TAP_B = 17;
    localparam logic [SCR_W-1:0] SCR_SEED = 23'd1;
endpackage

// File: rtl/mbw_lfsr.sv
module mbw_lfsr
    import mbw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [SCR_W-1:0] state
);
    logic fb;

    assign fb = state[SCR_TAP_A] ^ state[SCR_TAP_B];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= SCR_SEED;
        else if (step)
            state <= {state[SCR_W-2:0], fb};
    end
endmodule

// File: rtl/mbw_cfg.sv
module mbw_cfg #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CFG_W  = 32,
    parameter int unsigned ADDR_W = 32
) (
    input  logic [CFG_W-1:0]  base_bytes,
    input  logic [CFG_W-1:0]  end_bytes,
    input  logic [CFG_W-1:0]  len_bytes,
    output logic [ADDR_W-1:0] base_w,
    output logic [ADDR_W-1:0] mask_w,
    output logic [CFG_W-1:0]  count_w
);
    localparam int unsigned BYTES = DATA_W / 8;
    localparam int unsigned SH    = $clog2(BYTES);

    logic [CFG_W-1:0] span_b;
    logic [CFG_W-1:0] span_w;

    always_comb begin
        span_b  = end_bytes - base_bytes;
        span_w  = span_b >> SH;
        base_w  = ADDR_W'(base_bytes >> SH);
        mask_w  = ADDR_W'(span_w - CFG_W'(1));
        count_w = len_bytes >> SH;
    end
endmodule

// File: rtl/mbw_gen.sv
module mbw_gen
    import mbw_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CFG_W  = 32,
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CFG_W-1:0]  base_bytes,
    input  logic [CFG_W-1:0]  end_bytes,
    input  logic [CFG_W-1:0]  len_bytes,
    input  logic              rnd_addr,
    input  logic              rnd_data,
    output logic              done,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic              cmd_we,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              wd_valid,
    input  logic              wd_ready,
    output logic [DATA_W-1:0] wd_data
);
    mbw_state_e state_q, state_d;

    logic [ADDR_W-1:0] cfg_base, cfg_mask;
    logic [CFG_W-1:0]  cfg_count;
    logic [ADDR_W-1:0] base_q, mask_q;
    logic [CFG_W-1:0]  cnt_q, idx_q;
    logic              ra_q, rd_q;
    logic              cmd_ok_q, dat_ok_q;
    logic              cmd_fire, dat_fire, xfer_end, last_xfer, launch;
    logic [SCR_W-1:0]  scr;
    logic [ADDR_W-1:0] offset;

    mbw_cfg #(.DATA_W(DATA_W), .CFG_W(CFG_W), .ADDR_W(ADDR_W)) u_cfg (
        .base_bytes (base_bytes),
        .end_bytes  (end_bytes),
        .len_bytes  (len_bytes),
        .base_w     (cfg_base),
        .mask_w     (cfg_mask),
        .count_w    (cfg_count)
    );

    mbw_lfsr u_scr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (xfer_end),
        .state (scr)
    );

    assign cmd_fire  = cmd_valid & cmd_ready;
    assign dat_fire  = wd_valid & wd_ready;
    assign xfer_end  = (state_q == ST_XFER) & (cmd_ok_q | cmd_fire) & (dat_ok_q | dat_fire);
    assign last_xfer = (idx_q + CFG_W'(1)) == cnt_q;
    assign launch    = start & (state_q != ST_XFER);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE: if (start) state_d = (cfg_count == '0) ? ST_DONE : ST_XFER;
            ST_XFER:          if (xfer_end && last_xfer) state_d = ST_DONE;
            default:          state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // run datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q   <= '0;
            mask_q   <= '0;
            cnt_q    <= '0;
            idx_q    <= '0;
            ra_q     <= 1'b0;
            rd_q     <= 1'b0;
            cmd_ok_q <= 1'b0;
            dat_ok_q <= 1'b0;
        end else if (launch) begin
            base_q   <= cfg_base;
            mask_q   <= cfg_mask;
            cnt_q    <= cfg_count;
            idx_q    <= '0;
            ra_q     <= rnd_addr;
            rd_q     <= rnd_data;
            cmd_ok_q <= 1'b0;
            dat_ok_q <= 1'b0;
        end else if (xfer_end) begin
            idx_q    <= idx_q + CFG_W'(1);
            cmd_ok_q <= 1'b0;
            dat_ok_q <= 1'b0;
        end else begin
            if (cmd_fire) cmd_ok_q <= 1'b1;
            if (dat_fire) dat_ok_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        done      = 1'b1;
        cmd_valid = 1'b0;
        wd_valid  = 1'b0;
        cmd_we    = 1'b1;
        offset    = ra_q ? ADDR_W'(scr) : ADDR_W'(idx_q);
        cmd_addr  = base_q + (offset & mask_q);
        wd_data   = rd_q ? DATA_W'(scr) : DATA_W'(idx_q);
        unique case (state_q)
            ST_IDLE, ST_DONE: done = 1'b1;
            ST_XFER: begin
                done      = 1'b0;
                cmd_valid = ~cmd_ok_q;
                wd_valid  = ~dat_ok_q;
            end
            default: done = 1'b1;
        endcase
    end
endmodule

// File: rtl/mbw_gen_chk.sv
module mbw_gen_chk #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              done,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic              cmd_we,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic              wd_valid,
    input logic              wd_ready,
    input logic [DATA_W-1:0] wd_data,
    input logic [ADDR_W-1:0] win_base,
    input logic [ADDR_W-1:0] win_mask
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!cmd_valid && !wd_valid)); // R1

    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr))); // R9

    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_valid && !wd_ready) |=> (wd_valid && $stable(wd_data))); // R9

    AST_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> cmd_we); // R9

    AST_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (((cmd_addr - win_base) & ~win_mask) == '0)); // R5
endmodule

bind mbw_gen mbw_gen_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .done      (done),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_we    (cmd_we),
    .cmd_addr  (cmd_addr),
    .wd_valid  (wd_valid),
    .wd_ready  (wd_ready),
    .wd_data   (wd_data),
    .win_base  (base_q),
    .win_mask  (mask_q)
);

// File: tb/mbw_gen_tb.sv
module mbw_gen_tb;
    localparam int DATA_W = 32;
    localparam int CFG_W  = 32;
    localparam int ADDR_W = 32;
    localparam int WB     = DATA_W / 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [CFG_W-1:0] base_bytes = '0, end_bytes = '0, len_bytes = '0;
    logic rnd_addr = 1'b0, rnd_data = 1'b0;
    logic done, cmd_valid, cmd_we, wd_valid;
    logic cmd_ready = 1'b0, wd_ready = 1'b0;
    logic [ADDR_W-1:0] cmd_addr;
    logic [DATA_W-1:0] wd_data;

    int errors = 0;
    int checks = 0;
    int rdy_mode = 0;
    int cyc = 0;
    logic [22:0] m_scr = 23'd1;

    logic [ADDR_W-1:0] alog [0:255];
    logic [DATA_W-1:0] dlog [0:255];
    int an = 0, dn = 0, we_bad = 0;

    always #10 clk = ~clk;

    mbw_gen #(.DATA_W(DATA_W), .CFG_W(CFG_W), .ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .base_bytes(base_bytes), .end_bytes(end_bytes), .len_bytes(len_bytes),
        .rnd_addr(rnd_addr), .rnd_data(rnd_data), .done(done),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_we(cmd_we), .cmd_addr(cmd_addr),
        .wd_valid(wd_valid), .wd_ready(wd_ready), .wd_data(wd_data)
    );

    // ready rhythms, changed just after each rising edge
    always @(posedge clk) begin
        #1;
        cyc = cyc + 1;
        case (rdy_mode)
            0: begin cmd_ready = 1'b1; wd_ready = 1'b1; end
            1: begin cmd_ready = (cyc % 3) != 0; wd_ready = (cyc % 2) == 0; end
            2: begin cmd_ready = (cyc % 5) == 1; wd_ready = (cyc % 4) == 3; end
            default: begin cmd_ready = 1'b0; wd_ready = 1'b0; end
        endcase
    end

    // accepted-handshake logger, sampled mid-cycle
    always @(negedge clk) begin
        if (cmd_valid && cmd_ready && an < 256) begin
            alog[an] = cmd_addr;
            if (!cmd_we) we_bad = we_bad + 1;
            an = an + 1;
        end
        if (wd_valid && wd_ready && dn < 256) begin
            dlog[dn] = wd_data;
            dn = dn + 1;
        end
    end

    initial begin
        #4_000_000;
        errors = errors + 1;
        checks = checks + 1;
        $display("FAIL watchdog: run hung (actual=timeout expected=finish)");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    function automatic logic [22:0] scr_next(input logic [22:0] s);
        return {s[21:0], s[22] ^ s[17]};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        m_scr = 23'd1;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // one run: configure, start, optionally pulse start again, wait, compare
    task automatic run_case(input string req, input logic [CFG_W-1:0] b,
                            input logic [CFG_W-1:0] e, input logic [CFG_W-1:0] l,
                            input bit ra, input bit rd, input int mode, input bit dbl);
        int n;
        int t;
        logic [ADDR_W-1:0] bw, mk, off, ea;
        logic [DATA_W-1:0] ed;
        n  = int'(l / WB);
        bw = ADDR_W'(b / WB);
        mk = ADDR_W'((e - b) / WB) - 1;
        rdy_mode = mode;
        an = 0; dn = 0; we_bad = 0;
        @(negedge clk);
        base_bytes = b; end_bytes = e; len_bytes = l;
        rnd_addr = ra; rnd_data = rd; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done == (n == 0), req, "done after start (R1)", done, n == 0);
        if (dbl) begin
            repeat (3) @(negedge clk);
            base_bytes = b + 256; len_bytes = l + 64; rnd_addr = ~ra; rnd_data = ~rd;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        t = 0;
        while (!done && t < 20000) begin
            @(negedge clk);
            t = t + 1;
        end
        chk(done == 1'b1, req, "done reached (R1)", done, 1);
        chk(an == n, req, "command count (R4)", an, n);
        chk(dn == n, req, "data count (R4)", dn, n);
        chk(we_bad == 0, req, "write enable (R9)", we_bad, 0);
        for (int k = 0; k < n && k < 256; k++) begin
            off = ra ? ADDR_W'(m_scr) : ADDR_W'(k);
            ea  = bw + (off & mk);
            ed  = rd ? DATA_W'(m_scr) : DATA_W'(k);
            chk(alog[k] == ea, req, $sformatf("addr[%0d]", k), alog[k], ea);
            chk(dlog[k] == ed, req, $sformatf("data[%0d]", k), dlog[k], ed);
            m_scr = scr_next(m_scr);
        end
        base_bytes = b; end_bytes = e; len_bytes = l;
    endtask

    task automatic t_reset_state();
        chk(done == 1'b1, "R1", "done at reset", done, 1);
        chk(cmd_valid == 1'b0, "R1", "cmd_valid at reset", cmd_valid, 0);
        chk(wd_valid == 1'b0, "R1", "wd_valid at reset", wd_valid, 0);
    endtask

    // R3 R4 R6: sequential, full window, words 4..19 with data 0..15
    task automatic t_sequential();
        run_case("R3/R6", 32'd16, 32'd80, 32'd64, 1'b0, 1'b0, 0, 1'b0);
        chk(alog[0] == 4, "R3", "first word", alog[0], 4);
    endtask

    // R5: 8-word window, 16 transfers wrap back to word 4
    task automatic t_wrap();
        run_case("R5", 32'd16, 32'd48, 32'd64, 1'b0, 1'b0, 0, 1'b0);
        chk(alog[8] == 4, "R5", "wrapped word", alog[8], 4);
    endtask

    // R7 R9: random data under uneven backpressure
    task automatic t_rand_data();
        run_case("R7/R9", 32'd0, 32'd256, 32'd128, 1'b0, 1'b1, 1, 1'b0);
    endtask

    // R8: random address, sequential data, slow alternating readies
    task automatic t_rand_addr();
        run_case("R8", 32'd64, 32'd128, 32'd64, 1'b1, 1'b0, 2, 1'b0);
    endtask

    // R4: zero length finishes with no traffic
    task automatic t_zero_len();
        run_case("R4", 32'd16, 32'd80, 32'd2, 1'b0, 1'b0, 0, 1'b0);
    endtask

    // R10: second start during a run is ignored
    task automatic t_start_busy();
        run_case("R10", 32'd32, 32'd96, 32'd48, 1'b0, 1'b0, 1, 1'b1);
    endtask

    // R2: reset during a run, then scrambler restarts from seed
    task automatic t_reset_mid();
        rdy_mode = 1;
        @(negedge clk);
        base_bytes = 0; end_bytes = 256; len_bytes = 256; rnd_addr = 0; rnd_data = 1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (12) @(negedge clk);
        chk(done == 1'b0, "R2", "busy before reset", done, 0);
        rst_n = 1'b0;
        #2;
        chk(done == 1'b1, "R2", "done during reset", done, 1);
        chk(cmd_valid == 1'b0, "R2", "cmd_valid during reset", cmd_valid, 0);
        chk(wd_valid == 1'b0, "R2", "wd_valid during reset", wd_valid, 0);
        m_scr = 23'd1;
        @(negedge clk);
        rst_n = 1'b1;
        run_case("R2", 32'd0, 32'd64, 32'd32, 1'b0, 1'b1, 0, 1'b0);
        chk(dlog[0] == 1, "R2", "seed after reset", dlog[0], 1);
    endtask

    initial begin
        #5;
        t_reset_state();
        do_reset();
        t_reset_state();
        t_sequential();
        t_wrap();
        t_rand_data();
        t_rand_addr();
        t_zero_len();
        t_start_busy();
        t_reset_mid();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule